// File: doc/BRIEF.md
# Video Sync Timing and Polarity Detector

This block measures the timing of one video axis (pixels per line or lines per frame) in the pixel clock domain. It watches a raw sync line and a data-enable line and, once per sync period, reports the period length, the number of clocks the sync line stayed high after its rising edge, where active video starts and ends, the inferred sync polarity, the true sync width, and the back and front porch lengths.

The raw sync line is not assumed to idle at any particular level. The block always counts from the sync rising edge. When the sync line stays high for more than half the period, the high stretch must be porches plus active video, so the sync is classified as negative and the pulse width and active positions are re-referenced to the falling edge. A result is marked trustworthy only when two consecutive periods agree, and a loss of sync edges is flagged once the position counter saturates.

Top module: `sync_timing_detector`

## Requirements
- R1: `period_total` is the number of clocks between two consecutive sync rising edges; outputs update once per period, on the third clock edge after the rising edge appears at `sync_raw_in` (two input register stages, then the result register), and only from the second rising edge after reset or after a loss of signal.
- R2: `sync_count` is the number of clocks the synchronised sync line stayed high starting at its rising edge.
- R3: `pol_negative` is 1 when `sync_count` is strictly greater than `period_total` divided by two with the remainder dropped, else 0; a period of 1235 with a high count of 1228 reports 1, a period of 100 with a high count of 50 reports 0.
- R4: `sync_width` equals `sync_count` for positive polarity and `period_total - sync_count` for negative polarity.
- R5: `active_start` is the position of the first clock with data enable high and `active_end` is one past the last such clock, both counted from the sync rising edge (position 0) for positive polarity and from the sync falling edge for negative polarity.
- R6: `back_porch` equals `active_start - sync_width` and `front_porch` equals `period_total - active_end`, all modulo 2^CNT_W.
- R7: `timing_valid` is set by a period whose total and high count both equal those of the immediately preceding period, and cleared by a period that differs.
- R8: when the position counter reaches 2^CNT_W-1 with no rising edge, `no_signal` goes to 1 and `timing_valid` to 0; the next rising edge only restarts measurement, and the first complete period after it clears `no_signal`.
- R9: after reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_raw_in | input | 1 | Raw sync line, unknown polarity |
| de_in | input | 1 | Data enable / active video |
| period_total | output | CNT_W | Clocks per period |
| sync_count | output | CNT_W | High clocks after the rising edge |
| pol_negative | output | 1 | 1 = negative sync polarity inferred |
| sync_width | output | CNT_W | True sync pulse width |
| active_start | output | CNT_W | First active position from the reference edge |
| active_end | output | CNT_W | One past the last active position |
| back_porch | output | CNT_W | Clocks from end of sync to active start |
| front_porch | output | CNT_W | Clocks from active end to start of sync |
| timing_valid | output | 1 | Two consecutive periods agreed |
| no_signal | output | 1 | Counter saturated without a sync edge |

## Verification
The bench uses the default parameters, CNT_W of 12 and two input register stages, so that a real 1235-line period can be measured and saturation at 4095 is reached after a few thousand clocks of silence. With those values it covers both polarities, the exact half-period boundary on even and odd totals, alternating periods that must never become valid, and recovery after a lost signal.

// File: rtl/sync_timing_pkg.sv
// Package: shared types for the sync timing detector.
// Assumes: nothing; holds only types.
package sync_timing_pkg;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } sync_pol_e;

    // Per-clock view of the synchronised inputs.
    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
        logic de;
    } edge_info_t;

endpackage

// File: rtl/sync_input_stage.sv
// Module: sync_input_stage
// Registers the raw sync and data-enable lines through STAGES flops and
// derives sync rising and falling edges from the last stage.
// Assumes: STAGES >= 1; both lines share one register chain so they stay aligned.
module sync_input_stage
    import sync_timing_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic       de_in,
    output edge_info_t ev
);

    logic [STAGES-1:0][1:0] stg;
    logic [1:0]             tail;
    logic                   sync_prev;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {de_in, sync_in};
            end
        end else begin : g_chain
            // Shift both lines down the register chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], {de_in, sync_in}};
            end
        end
    endgenerate

    assign tail = stg[STAGES-1];

    // Previous synchronised sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= 1'b0;
        else        sync_prev <= tail[0];
    end

    // Edge decode.
    always_comb begin
        ev.level = tail[0];
        ev.de    = tail[1];
        ev.rise  = tail[0] & ~sync_prev;
        ev.fall  = ~tail[0] & sync_prev;
    end

endmodule

// File: rtl/sync_period_counter.sv
// Module: sync_period_counter
// Counts clock positions from the last sync rising edge (position 0),
// records the falling-edge position and the first / one-past-last data
// enable positions, and presents the finished period on a rising edge.
// Assumes: the counter saturates at all-ones; a period that saturated is dropped.
module sync_period_counter
    import sync_timing_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  edge_info_t   ev,
    output logic         period_done,
    output logic         sat_hit,
    output logic [W-1:0] end_total,
    output logic [W-1:0] end_high,
    output logic [W-1:0] end_first,
    output logic [W-1:0] end_last1
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] pos_q;
    logic [W-1:0] fall_q;
    logic [W-1:0] first_q;
    logic [W-1:0] last1_q;
    logic         seen_q;
    logic         armed_q;

    // Position counting and per-period edge / enable capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            fall_q  <= '0;
            first_q <= '0;
            last1_q <= '0;
            seen_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (ev.rise) begin
            armed_q <= 1'b1;
            pos_q   <= W'(1);
            fall_q  <= '0;
            first_q <= '0;
            seen_q  <= ev.de;
            last1_q <= ev.de ? W'(1) : '0;
        end else begin
            if (pos_q == CNT_MAX) armed_q <= 1'b0;
            else                  pos_q   <= pos_q + W'(1);
            if (ev.fall) fall_q <= pos_q;
            if (ev.de) begin
                if (!seen_q) first_q <= pos_q;
                last1_q <= pos_q + W'(1);
                seen_q  <= 1'b1;
            end
        end
    end

    // Finished-period view, valid in the rising-edge cycle.
    always_comb begin
        period_done = ev.rise & armed_q & (pos_q != CNT_MAX);
        sat_hit     = ~ev.rise & (pos_q == CNT_MAX);
        end_total   = pos_q;
        end_high    = fall_q;
        end_first   = first_q;
        end_last1   = last1_q;
    end

endmodule

// File: rtl/sync_timing_solver.sv
// Module: sync_timing_solver
// Infers polarity from the rising-edge high count and derives sync width,
// reference-edge active positions and porches. Purely combinational.
// Assumes: inputs are rising-edge referenced; arithmetic wraps modulo 2^W.
module sync_timing_solver
    import sync_timing_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] total,
    input  logic [W-1:0] high,
    input  logic [W-1:0] first,
    input  logic [W-1:0] last1,
    output sync_pol_e    pol,
    output logic [W-1:0] width,
    output logic [W-1:0] act_start,
    output logic [W-1:0] act_end,
    output logic [W-1:0] bporch,
    output logic [W-1:0] fporch
);

    logic [W-1:0] low_len;
    logic [W-1:0] shift;

    // Polarity decision and re-referencing to the true sync start.
    always_comb begin
        low_len   = total - high;
        pol       = (high > (total >> 1)) ? POL_NEG : POL_POS;
        width     = (pol == POL_NEG) ? low_len : high;
        shift     = (pol == POL_NEG) ? low_len : '0;
        act_start = shift + first;
        act_end   = shift + last1;
        bporch    = act_start - width;
        fporch    = total - act_end;
    end

endmodule

// File: rtl/sync_timing_detector.sv
// Module: sync_timing_detector (top)
// Measures one video axis from a raw sync line and a data-enable line,
// infers sync polarity, and latches period, porch and width results once
// per period. Flags stability after two matching periods and loss of signal
// when the position counter saturates.
// Assumes: all inputs are in the clk domain or tolerate SYNC_STAGES flops.
module sync_timing_detector
    import sync_timing_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_raw_in,
    input  logic             de_in,
    output logic [CNT_W-1:0] period_total,
    output logic [CNT_W-1:0] sync_count,
    output logic             pol_negative,
    output logic [CNT_W-1:0] sync_width,
    output logic [CNT_W-1:0] active_start,
    output logic [CNT_W-1:0] active_end,
    output logic [CNT_W-1:0] back_porch,
    output logic [CNT_W-1:0] front_porch,
    output logic             timing_valid,
    output logic             no_signal
);

    edge_info_t       ev;
    logic             period_done;
    logic             sat_hit;
    logic [CNT_W-1:0] end_total, end_high, end_first, end_last1;
    sync_pol_e        s_pol;
    logic [CNT_W-1:0] s_width, s_start, s_end, s_bp, s_fp;
    logic [CNT_W-1:0] prev_total, prev_high;
    logic             have_prev;

    sync_input_stage #(.STAGES(SYNC_STAGES)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_raw_in),
        .de_in   (de_in),
        .ev      (ev)
    );

    sync_period_counter #(.W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .period_done (period_done),
        .sat_hit     (sat_hit),
        .end_total   (end_total),
        .end_high    (end_high),
        .end_first   (end_first),
        .end_last1   (end_last1)
    );

    sync_timing_solver #(.W(CNT_W)) u_solve (
        .total     (end_total),
        .high      (end_high),
        .first     (end_first),
        .last1     (end_last1),
        .pol       (s_pol),
        .width     (s_width),
        .act_start (s_start),
        .act_end   (s_end),
        .bporch    (s_bp),
        .fporch    (s_fp)
    );

    // Result latch, stability tracking and loss-of-signal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_total <= '0;
            sync_count   <= '0;
            pol_negative <= 1'b0;
            sync_width   <= '0;
            active_start <= '0;
            active_end   <= '0;
            back_porch   <= '0;
            front_porch  <= '0;
            timing_valid <= 1'b0;
            no_signal    <= 1'b0;
            prev_total   <= '0;
            prev_high    <= '0;
            have_prev    <= 1'b0;
        end else if (period_done) begin
            period_total <= end_total;
            sync_count   <= end_high;
            pol_negative <= (s_pol == POL_NEG);
            sync_width   <= s_width;
            active_start <= s_start;
            active_end   <= s_end;
            back_porch   <= s_bp;
            front_porch  <= s_fp;
            timing_valid <= have_prev && (end_total == prev_total)
                            && (end_high == prev_high);
            no_signal    <= 1'b0;
            prev_total   <= end_total;
            prev_high    <= end_high;
            have_prev    <= 1'b1;
        end else if (sat_hit) begin
            no_signal    <= 1'b1;
            timing_valid <= 1'b0;
            have_prev    <= 1'b0;
        end
    end

endmodule

// File: rtl/sync_timing_detector_chk.sv
// Module: sync_timing_detector_chk
// Property checks on the detector's result ports, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module sync_timing_detector_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] period_total,
    input logic [W-1:0] sync_count,
    input logic         pol_negative,
    input logic [W-1:0] sync_width,
    input logic [W-1:0] active_start,
    input logic [W-1:0] active_end,
    input logic [W-1:0] back_porch,
    input logic [W-1:0] front_porch,
    input logic         timing_valid,
    input logic         no_signal
);

    logic [W-1:0] span_sum;
    logic [W-1:0] half_total;

    // Sum of all parts of a period, modulo 2^W.
    assign span_sum   = back_porch + front_porch + sync_width + (active_end - active_start);
    assign half_total = period_total >> 1;

    AST_POL_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        timing_valid |-> (pol_negative == (sync_count > half_total))); // R3

    AST_POS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_negative |-> (sync_width == sync_count)); // R4

    AST_NEG_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        pol_negative |-> (sync_width == period_total - sync_count)); // R4

    AST_SPAN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        timing_valid |-> (span_sum == period_total)); // R6

    AST_VALID_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_valid) |-> ($stable(period_total) && $stable(sync_count))); // R7

    AST_NOSIG_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        no_signal |-> !timing_valid); // R8

endmodule

bind sync_timing_detector sync_timing_detector_chk #(.W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_total (period_total),
    .sync_count   (sync_count),
    .pol_negative (pol_negative),
    .sync_width   (sync_width),
    .active_start (active_start),
    .active_end   (active_end),
    .back_porch   (back_porch),
    .front_porch  (front_porch),
    .timing_valid (timing_valid),
    .no_signal    (no_signal)
);

// File: tb/sync_timing_detector_test.sv
// Bench: behavioural per-clock reference model compared on every clock.
module sync_timing_detector_test;

    localparam int W  = 12;
    localparam int MX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_d = 1'b0;
    logic de_d = 1'b0;

    logic [W-1:0] period_total, sync_count, sync_width, active_start, active_end;
    logic [W-1:0] back_porch, front_porch;
    logic         pol_negative, timing_valid, no_signal;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    sync_timing_detector uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_raw_in  (sync_d),
        .de_in        (de_d),
        .period_total (period_total),
        .sync_count   (sync_count),
        .pol_negative (pol_negative),
        .sync_width   (sync_width),
        .active_start (active_start),
        .active_end   (active_end),
        .back_porch   (back_porch),
        .front_porch  (front_porch),
        .timing_valid (timing_valid),
        .no_signal    (no_signal)
    );

    // Reference model state.
    int hs[$], hd[$];
    int pos, fpos, first, last1, prevT, prevS;
    bit armed, seen, havep;
    int eT, eS, eW, eAS, eAE, eBP, eFP;
    bit eNeg, eV, eNS;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_reset();
        hs = '{0, 0, 0, 0};
        hd = '{0, 0, 0, 0};
        pos = 0; fpos = 0; first = 0; last1 = 0; prevT = 0; prevS = 0;
        armed = 0; seen = 0; havep = 0;
        eT = 0; eS = 0; eW = 0; eAS = 0; eAE = 0; eBP = 0; eFP = 0;
        eNeg = 0; eV = 0; eNS = 0;
    endtask

    // Reference model: sync/DE seen by the design at edge m were driven two edges earlier.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            model_reset();
        end else begin
            int x, px, de, sh;
            hs.push_front(int'(sync_d)); void'(hs.pop_back());
            hd.push_front(int'(de_d));   void'(hd.pop_back());
            x = hs[2]; px = hs[3]; de = hd[2];
            if (x == 1 && px == 0) begin
                if (armed && pos != MX) begin
                    eT = pos; eS = fpos;
                    eNeg = (eS > eT / 2);
                    eW = eNeg ? ((eT - eS) & MX) : eS;
                    sh = eNeg ? ((eT - eS) & MX) : 0;
                    eAS = (sh + first) & MX;
                    eAE = (sh + last1) & MX;
                    eBP = (eAS - eW) & MX;
                    eFP = (eT - eAE) & MX;
                    eV = havep && eT == prevT && eS == prevS;
                    prevT = eT; prevS = eS; havep = 1; eNS = 0;
                end
                armed = 1; pos = 1; fpos = 0; first = 0;
                seen = (de == 1); last1 = (de == 1) ? 1 : 0;
            end else begin
                if (pos == MX) begin
                    armed = 0; eNS = 1; eV = 0; havep = 0;
                end
                if (x == 0 && px == 1) fpos = pos;
                if (de == 1) begin
                    if (!seen) first = pos;
                    last1 = (pos + 1) & MX;
                    seen = 1;
                end
                if (pos != MX) pos = pos + 1;
            end
        end
    end

    // Compare every output on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(period_total == eT, "R1 period_total", period_total, eT);
            chk(sync_count == eS, "R2 sync_count", sync_count, eS);
            chk(pol_negative == eNeg, "R3 pol_negative", pol_negative, eNeg);
            chk(sync_width == eW, "R4 sync_width", sync_width, eW);
            chk(active_start == eAS, "R5 active_start", active_start, eAS);
            chk(active_end == eAE, "R5 active_end", active_end, eAE);
            chk(back_porch == eBP, "R6 back_porch", back_porch, eBP);
            chk(front_porch == eFP, "R6 front_porch", front_porch, eFP);
            chk(timing_valid == eV, "R7 timing_valid", timing_valid, eV);
            chk(no_signal == eNS, "R8 no_signal", no_signal, eNS);
        end
    end

    task automatic frames(input int tot, input int hi, input int dfirst, input int dlen, input int reps);
        for (int r = 0; r < reps; r++) begin
            for (int p = 0; p < tot; p++) begin
                @(negedge clk);
                sync_d = (p < hi);
                de_d   = (p >= dfirst) && (p < dfirst + dlen);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sync_d = 1'b0;
            de_d   = 1'b0;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(period_total == 0 && sync_count == 0 && !pol_negative && sync_width == 0 &&
            active_start == 0 && active_end == 0 && back_porch == 0 && front_porch == 0 &&
            !timing_valid && !no_signal, "R9 reset outputs", 1, 0);
        rst_n = 1'b1;
        idle(5);
        // R1/R2 positive sync, short pulse
        frames(100, 6, 20, 70, 4);
        chk(timing_valid == 1 && pol_negative == 0, "R7 valid positive", timing_valid, 1);
        // Negative sync: high through porches and active
        frames(100, 92, 10, 70, 4);
        chk(pol_negative == 1 && sync_width == 8, "R4 negative width", sync_width, 8);
        chk(back_porch == 10, "R6 negative back porch", back_porch, 10);
        // R3: worked example 1235 / 1228
        frames(1235, 1228, 20, 1200, 3);
        chk(pol_negative == 1, "R3 1235/1228 negative", pol_negative, 1);
        // R3 boundaries: exactly half, one above, odd total
        frames(100, 50, 60, 30, 3);
        chk(pol_negative == 0, "R3 half is positive", pol_negative, 0);
        frames(100, 51, 5, 40, 3);
        chk(pol_negative == 1, "R3 above half negative", pol_negative, 1);
        frames(101, 51, 5, 40, 3);
        chk(pol_negative == 1, "R3 odd total negative", pol_negative, 1);
        // R7: alternating periods never validate
        for (int k = 0; k < 3; k++) begin
            frames(100, 6, 20, 70, 1);
            frames(102, 6, 20, 70, 1);
        end
        chk(timing_valid == 0, "R7 alternating not valid", timing_valid, 0);
        // R8: loss of signal, then recovery
        idle(4200);
        chk(no_signal == 1 && timing_valid == 0, "R8 saturation flags", no_signal, 1);
        frames(100, 6, 20, 70, 1);
        chk(no_signal == 1, "R8 first edge only restarts", no_signal, 1);
        frames(100, 6, 20, 70, 3);
        idle(4);
        chk(no_signal == 0 && timing_valid == 1, "R8 recovered", no_signal, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule